// File: doc/BRIEF.md
# DTMF Tone-Pair Period Classifier

This block sits behind a pair of zero-crossing comparators in a touch-tone receiver. It gets two digital square waves: one from the low (row) band and one from the high (column) band. Each waveform's period is timed by counting cycles of the reference clock between rising edges. The measured period is compared against a window built around each of four nominal tones. When a group's period falls in a window, that group reports a match and the index of the matching tone.

The two groups are tracked independently. The block counts consecutive in-window periods that carry the same tone index. When both groups have two such periods in a row, the block raises a tone-present flag and drives a 4-bit keypad code. An inhibit input removes the fourth column (the letter keys) from what may be reported. Timing rules that decide whether a digit is finally accepted are left to a steering stage downstream.

The windows are computed at elaboration from the clock frequency and a tolerance. The default tolerance is ±2.5 %, which lies between the accept bound and the reject bound.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: While the synchronous active-high reset is high, and on the cycle after it is released, `tonePresent` is 0.
- R2: A tone pair at nominal frequencies is detected. Rows are 697/770/852/941 Hz and columns are 1209/1336/1477/1633 Hz, timed in reference-clock cycles. The pair drives `digitCode` using this keypad map: digits 1 to 9 give 1 to 9, 0 gives 10, * gives 11, # gives 12, and the letter keys A, B, C, D (the 1633 Hz column, rows in ascending order) give 13, 14, 15 and 0.
- R3: A tone whose frequency is off nominal by up to ±1.5 % is classified as that tone.
- R4: A tone whose frequency is off every nominal tone by 3.5 % or more matches no tone, and no digit is reported.
- R5: While `inhibitTopCol` is 1, no pair using the 1633 Hz column raises `tonePresent`. The other columns are not affected, and releasing the inhibit lets a held letter pair report at once.
- R6: `tonePresent` rises only when each group has measured two consecutive in-window periods with the same tone index. Counting from a silent start, this is after the third rising edge of each group, and never after the second.
- R7: Two events clear `tonePresent`: a measured period outside every window, or a group that shows no rising edge for longer than its longest window. In both cases a fresh run of two good periods is needed again.
- R8: A tone in only one group never raises `tonePresent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; periods are counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| lowSq | input | 1 | Squared row-band waveform, synchronous to clk |
| highSq | input | 1 | Squared column-band waveform, synchronous to clk |
| inhibitTopCol | input | 1 | When 1, blocks reporting of 1633 Hz column pairs |
| digitCode | output | 4 | Keypad code of the held row/column indices |
| tonePresent | output | 1 | Both groups stable on a valid, permitted pair |

## Verification
The bench sweeps all sixteen pairs, and each run starts from silence. In every run it samples once after the second edge and once after the third. A tracker that counts the first, bogus period, or that needs only one period, shows up as an early flag. Frequencies are pushed to ±1.5 % and to ±3.5 % at the ends of each band. Windows computed with the wrong divisor or the wrong rounding would reject the first set or accept the second. The bench also covers these cases:
- the inhibit on the letter column and on a plain column;
- a single long period inside an established tone, which must drop the flag until two good periods have passed again;
- a tone in one group only;
- silence after a tone, which a timer without a timeout would leave asserted.

// File: rtl/tone_cls_pkg.sv
package tone_cls_pkg;

  localparam int NUM_TONES = 4;
  localparam int IDX_W     = $clog2(NUM_TONES);

  // strobes from tracker to datapath
  typedef struct packed {
    logic lowCapture;
    logic highCapture;
  } trackStrobe_t;

  // observations from datapath to tracker
  typedef struct packed {
    logic lowRise;
    logic lowHit;
    logic lowSame;
    logic lowStale;
    logic highRise;
    logic highHit;
    logic highSame;
    logic highStale;
    logic highTopCol;
  } periodObs_t;

  function automatic int toneHz(input bit isHigh, input int idx);
    int hz;
    case (idx)
      0: hz = isHigh ? 1209 : 697;
      1: hz = isHigh ? 1336 : 770;
      2: hz = isHigh ? 1477 : 852;
      default: hz = isHigh ? 1633 : 941;
    endcase
    return hz;
  endfunction

  // shortest accepted period: ceil(clk / (hz * (1 + tol)))
  function automatic int winLo(input int clkHz, input int hz, input int tolPm);
    longint num;
    longint den;
    num = longint'(clkHz) * 1000;
    den = longint'(hz) * (1000 + tolPm);
    return int'((num + den - 1) / den);
  endfunction

  // longest accepted period: floor(clk / (hz * (1 - tol)))
  function automatic int winHi(input int clkHz, input int hz, input int tolPm);
    longint num;
    longint den;
    num = longint'(clkHz) * 1000;
    den = longint'(hz) * (1000 - tolPm);
    return int'(num / den);
  endfunction

  function automatic int periodCntW(input int clkHz, input int tolPm);
    return $clog2(winHi(clkHz, toneHz(1'b0, 0), tolPm) + 2);
  endfunction

endpackage

// File: rtl/tone_group_timer.sv
module tone_group_timer
  import tone_cls_pkg::*;
#(
  parameter int CLK_HZ  = 3579545,
  parameter int TOL_PM  = 25,
  parameter bit IS_HIGH = 1'b0,
  parameter int CNT_W   = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sq,
  input  logic             capture,
  output logic             rise,
  output logic             hit,
  output logic             same,
  output logic             stale,
  output logic [IDX_W-1:0] heldIdx
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] STALE_LIM =
    CNT_W'(winHi(CLK_HZ, toneHz(IS_HIGH, 0), TOL_PM));

  logic             sqPrev;
  logic [CNT_W-1:0] cyc;
  logic [NUM_TONES-1:0] inWin;
  logic [IDX_W-1:0] matchIdx;

  assign rise = sq & ~sqPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sqPrev <= 1'b0;
      cyc    <= '0;
    end else begin
      sqPrev <= sq;
      if (rise)
        cyc <= CNT_W'(1);
      else if (cyc != CNT_MAX)
        cyc <= cyc + CNT_W'(1);
    end
  end

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_win
    localparam logic [CNT_W-1:0] LO =
      CNT_W'(winLo(CLK_HZ, toneHz(IS_HIGH, t), TOL_PM));
    localparam logic [CNT_W-1:0] HI =
      CNT_W'(winHi(CLK_HZ, toneHz(IS_HIGH, t), TOL_PM));
    assign inWin[t] = (cyc >= LO) && (cyc <= HI);
  end

  always_comb begin
    matchIdx = '0;
    for (int t = 0; t < NUM_TONES; t++)
      if (inWin[t]) matchIdx = IDX_W'(t);
  end

  assign hit   = rise && (|inWin);
  assign same  = (matchIdx == heldIdx);
  assign stale = (cyc > STALE_LIM);

  always_ff @(posedge clk) begin
    if (rst)
      heldIdx <= '0;
    else if (capture)
      heldIdx <= matchIdx;
  end

endmodule

// File: rtl/tone_period_dp.sv
module tone_period_dp
  import tone_cls_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter int TOL_PM = 25,
  parameter int CNT_W  = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lowSq,
  input  logic         highSq,
  input  trackStrobe_t strobe,
  output periodObs_t   obs,
  output logic [3:0]   digitCode
);

  logic [IDX_W-1:0] rowIdx;
  logic [IDX_W-1:0] colIdx;

  tone_group_timer #(
    .CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .IS_HIGH(1'b0), .CNT_W(CNT_W)
  ) u_low (
    .clk(clk), .rst(rst), .sq(lowSq), .capture(strobe.lowCapture),
    .rise(obs.lowRise), .hit(obs.lowHit), .same(obs.lowSame),
    .stale(obs.lowStale), .heldIdx(rowIdx)
  );

  tone_group_timer #(
    .CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .IS_HIGH(1'b1), .CNT_W(CNT_W)
  ) u_high (
    .clk(clk), .rst(rst), .sq(highSq), .capture(strobe.highCapture),
    .rise(obs.highRise), .hit(obs.highHit), .same(obs.highSame),
    .stale(obs.highStale), .heldIdx(colIdx)
  );

  assign obs.highTopCol = (colIdx == IDX_W'(NUM_TONES - 1));

  // keypad order: letter column 13..16 (wraps), bottom row * 0 #
  function automatic logic [3:0] keyCode(input logic [IDX_W-1:0] r,
                                         input logic [IDX_W-1:0] c);
    logic [3:0] k;
    if (c == 2'd3)
      k = 4'd13 + 4'(r);
    else if (r != 2'd3)
      k = 4'(r) * 4'd3 + 4'(c) + 4'd1;
    else begin
      case (c)
        2'd0:    k = 4'd11;
        2'd1:    k = 4'd10;
        default: k = 4'd12;
      endcase
    end
    return k;
  endfunction

  assign digitCode = keyCode(rowIdx, colIdx);

endmodule

// File: rtl/tone_track_ctl.sv
module tone_track_ctl
  import tone_cls_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inhibitTopCol,
  input  periodObs_t   obs,
  output trackStrobe_t strobe,
  output logic         tonePresent
);

  localparam logic [1:0] RUN_DONE = 2'd2;

  logic [1:0] lowRun;
  logic [1:0] highRun;

  function automatic logic [1:0] nextRun(input logic [1:0] cur,
                                         input logic edgeSeen,
                                         input logic inWindow,
                                         input logic sameIdx,
                                         input logic timedOut);
    logic [1:0] n;
    n = cur;
    if (edgeSeen) begin
      if (!inWindow)
        n = 2'd0;
      else if (sameIdx && cur != 2'd0)
        n = (cur == RUN_DONE) ? RUN_DONE : cur + 2'd1;
      else
        n = 2'd1;
    end else if (timedOut) begin
      n = 2'd0;
    end
    return n;
  endfunction

  assign strobe.lowCapture  = obs.lowRise && obs.lowHit;
  assign strobe.highCapture = obs.highRise && obs.highHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowRun  <= 2'd0;
      highRun <= 2'd0;
    end else begin
      lowRun  <= nextRun(lowRun, obs.lowRise, obs.lowHit, obs.lowSame, obs.lowStale);
      highRun <= nextRun(highRun, obs.highRise, obs.highHit, obs.highSame, obs.highStale);
    end
  end

  assign tonePresent = (lowRun == RUN_DONE) && (highRun == RUN_DONE)
                       && !(inhibitTopCol && obs.highTopCol);

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
  import tone_cls_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter int TOL_PM = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lowSq,
  input  logic       highSq,
  input  logic       inhibitTopCol,
  output logic [3:0] digitCode,
  output logic       tonePresent
);

  localparam int CNT_W = periodCntW(CLK_HZ, TOL_PM);

  trackStrobe_t strobe;
  periodObs_t   obs;

  tone_period_dp #(.CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .lowSq(lowSq), .highSq(highSq),
    .strobe(strobe), .obs(obs), .digitCode(digitCode)
  );

  tone_track_ctl u_ctl (
    .clk(clk), .rst(rst), .inhibitTopCol(inhibitTopCol),
    .obs(obs), .strobe(strobe), .tonePresent(tonePresent)
  );

endmodule

// File: rtl/tone_cls_checker.sv
module tone_cls_checker
  import tone_cls_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       inhibit,
  input logic       present,
  input logic [3:0] code,
  input periodObs_t obs
);

  // R5: letter-column codes never reported while inhibited
  p_inhibit_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (present && inhibit) |-> !(code inside {4'd13, 4'd14, 4'd15, 4'd0}));

  // R6: the flag only rises after a measured edge or an inhibit release
  p_rise_after_edge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(present) |-> ($past(obs.lowRise || obs.highRise) || $fell(inhibit)));

  // R2: the reported code does not move without a new edge
  p_code_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (present && $past(present) && !$past(obs.lowRise) && !$past(obs.highRise))
      |-> $stable(code));

  // R7: a timed-out group clears the flag on the next cycle
  p_stale_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (obs.lowStale || obs.highStale) |=> !present);

endmodule

bind dtmf_pair_classifier tone_cls_checker u_chk (
  .clk(clk), .rst(rst), .inhibit(inhibitTopCol),
  .present(tonePresent), .code(digitCode), .obs(obs)
);

// File: tb/tb_dtmf_pair_classifier.sv
module tb_dtmf_pair_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 357954;
  localparam int IDLE_CYC   = 800;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lowSq = 1'b0;
  logic       highSq = 1'b0;
  logic       inhibitTopCol = 1'b0;
  logic [3:0] digitCode;
  logic       tonePresent;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int rowF[4] = '{697, 770, 852, 941};
  int colF[4] = '{1209, 1336, 1477, 1633};
  string keyRows[4] = '{"123A", "456B", "789C", "*0#D"};

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmf_pair_classifier #(.CLK_HZ(CLK_HZ), .TOL_PM(25)) dut (
    .clk(clk), .rst(rst), .lowSq(lowSq), .highSq(highSq),
    .inhibitTopCol(inhibitTopCol), .digitCode(digitCode),
    .tonePresent(tonePresent)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int per(input int f, input real dev);
    return $rtoi(real'(CLK_HZ) / (real'(f) * (1.0 + dev)) + 0.5);
  endfunction

  function automatic int expCode(input int r, input int c);
    byte ch;
    ch = keyRows[r][c];
    if (ch >= "1" && ch <= "9") return ch - "0";
    if (ch == "0") return 10;
    if (ch == "*") return 11;
    if (ch == "#") return 12;
    return (13 + (ch - "A")) % 16;
  endfunction

  task automatic genLow(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      lowSq = 1'b1;
      repeat (p/2) @(negedge clk);
      lowSq = 1'b0;
      repeat (p - p/2) @(negedge clk);
    end
  endtask

  task automatic genHigh(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      highSq = 1'b1;
      repeat (p/2) @(negedge clk);
      highSq = 1'b0;
      repeat (p - p/2) @(negedge clk);
    end
  endtask

  task automatic idle();
    repeat (IDLE_CYC) @(negedge clk);
  endtask

  // one pair from silence: early sample (R6), late sample, then silence (R7)
  task automatic testPair(input int r, input int c, input real devL,
                          input real devH, input bit expP, input string req);
    int pl;
    int ph;
    pl = per(rowF[r], devL);
    ph = per(colF[c], devH);
    fork
      genLow(pl, 3);
      genHigh(ph, (3*pl)/ph + 1);
      begin
        repeat ((3*pl)/2) @(negedge clk);
        chk("R6 early", tonePresent, 0);
        repeat ((5*pl)/2 - (3*pl)/2) @(negedge clk);
        chk(req, tonePresent, expP);
        if (expP) chk({req, " code"}, digitCode, expCode(r, c));
      end
    join
    idle();
    chk("R7 silence", tonePresent, 0);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int pl;
    int ph;
    int pb;
    int w1;
    int w2;
    repeat (3) @(negedge clk);
    chk("R1 in reset", tonePresent, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", tonePresent, 0);

    // R2 all sixteen nominal pairs
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        testPair(r, c, 0.0, 0.0, 1'b1, "R2 nominal");

    // R3 accept at +/-1.5 %
    for (int i = 0; i < 4; i++) begin
      testPair(i, i, 0.015, 0.015, 1'b1, "R3 plus");
      testPair(i, 3 - i, -0.015, -0.015, 1'b1, "R3 minus");
    end

    // R4 reject at 3.5 %
    for (int i = 0; i < 4; i++) begin
      testPair(i, 0, 0.035, 0.0, 1'b0, "R4 row high");
      testPair(0, i, 0.0, -0.035, 1'b0, "R4 col low");
    end

    // R5 inhibit
    inhibitTopCol = 1'b1;
    for (int r = 0; r < 4; r++)
      testPair(r, 3, 0.0, 0.0, 1'b0, "R5 letter blocked");
    testPair(0, 0, 0.0, 0.0, 1'b1, "R5 plain column");
    testPair(2, 1, 0.0, 0.0, 1'b1, "R5 plain column");

    pl = per(rowF[1], 0.0);
    ph = per(colF[3], 0.0);
    fork
      genLow(pl, 3);
      genHigh(ph, (3*pl)/ph + 1);
      begin
        repeat ((5*pl)/2) @(negedge clk);
        chk("R5 held letter", tonePresent, 0);
        inhibitTopCol = 1'b0;
        @(negedge clk);
        chk("R5 release", tonePresent, 1);
        chk("R5 release code", digitCode, expCode(1, 3));
      end
    join
    idle();

    // R7 one long period inside a running tone
    pl = per(rowF[0], 0.0);
    ph = per(colF[0], 0.0);
    pb = pl + pl/16;
    fork
      begin
        genLow(pl, 3);
        genLow(pb, 1);
        genLow(pl, 3);
      end
      genHigh(ph, (6*pl + pb)/ph + 1);
      begin
        w1 = (5*pl)/2;
        repeat (w1) @(negedge clk);
        chk("R7 before bad", tonePresent, 1);
        w2 = 3*pl + pb + pl/2 - w1;
        repeat (w2) @(negedge clk);
        chk("R7 bad period", tonePresent, 0);
        repeat (3*pl + pb + (5*pl)/2 - (w1 + w2)) @(negedge clk);
        chk("R7 recovered", tonePresent, 1);
      end
    join
    idle();

    // R8 low group alone
    fork
      genLow(pl, 3);
      begin
        repeat ((5*pl)/2) @(negedge clk);
        chk("R8 low only", tonePresent, 0);
      end
    join
    idle();

    // R8 high group alone
    fork
      genHigh(ph, 10);
      begin
        repeat (9*ph) @(negedge clk);
        chk("R8 high only", tonePresent, 0);
      end
    join
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule